// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns single internal read and write requests into cycles on an external bus. The bus has sixteen shared address/data lines, an address-latch strobe and two active-low data strobes. The bus carries the address first. The external latch captures it on the falling edge of the latch strobe. The same lines then carry the data, or are released so that the device can drive read data.

Two device widths are supported. For a 16-bit device the address is 16 bits and goes out in one latch phase. For an 8-bit device the address is 24 bits. Its top byte goes out in a first latch phase and its low 16 bits in a second. Data then uses only the low byte of the bus.

Three timing values are taken from plain configuration pins when a request is accepted:
- the extra cycles of each latch pulse;
- the wait states of the data strobe;
- the cycles of data hold after the strobe.

Requests enter on a valid/ready handshake:
- `req_ready` is high only while the master is idle.
- A request must hold its fields steady until the cycle in which `req_valid` and `req_ready` are both high.
- `req_ready` stays low from acceptance until the transaction ends.

Completion is a one-cycle `rsp_done` strobe that cannot be back-pressured. `rsp_rdata` holds the most recent read result.

Top module: `mxbus_master`

## Requirements
- R1: `req_ready` is high exactly while the master is idle. A request is taken on a clock edge with `req_valid` and `req_ready` both high. The next request can be taken in the cycle after `rsp_done`.
- R2: In 16-bit mode (`req_wide`=1) there is one address phase. `bus_ale` is high for `cfg_ale`+1 cycles with `bus_ad_out` = addr[15:0] and `bus_ad_oe`=1. This is followed by one cycle with `bus_ale` low and the address still driven.
- R3: In 8-bit mode (`req_wide`=0) there are two address phases of the R2 shape. The first drives `bus_ad_out` = {8'h00, addr[23:16]}. The second drives addr[15:0].
- R4: `bus_rd_n` and `bus_wr_n` are never low while `bus_ale` is high, and never low together.
- R5: For a write, `bus_wr_n` is low for `cfg_wait`+1 cycles, and the data stays driven for `cfg_hold` further cycles with `bus_wr_n` high. The data is wdata in 16-bit mode and {8'h00, wdata[7:0]} in 8-bit mode.
- R6: For a read, `bus_rd_n` is low for `cfg_wait`+1 cycles, followed by `cfg_hold` cycles with it high. `bus_ad_oe` is 0 throughout both.
- R7: `rsp_rdata` takes the `bus_ad_in` value from the last cycle with `bus_rd_n` low, on the edge where `bus_rd_n` rises. It is zero-extended from bits [7:0] in 8-bit mode. It changes at no other time.
- R8: `rsp_done` is high for exactly one cycle, directly after the hold cycles. With `cfg_hold`=0 it comes directly after the strobe.
- R9: While `rst_n` is low: `bus_ale`=0, `bus_rd_n`=`bus_wr_n`=1, `bus_ad_oe`=0, `req_ready`=1, `rsp_done`=0.
- R10: The configuration pins are sampled only at acceptance. Changing them during a transaction does not affect that transaction's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Master idle, request can be taken |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| cfg_ale | input | 4 | Extra latch-pulse cycles |
| cfg_wait | input | 4 | Data-strobe wait states |
| cfg_hold | input | 4 | Hold cycles after the strobe |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Last read result |
| bus_ad_out | output | 16 | Address/data lines, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the address/data lines |
| bus_ad_in | input | 16 | Address/data lines, incoming value |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The embedded assertions check the following on every cycle:
- the strobe exclusions against the latch strobe;
- that the lines are released while the read strobe is low;
- that completion is a single pulse and is followed by idle;
- that the read result moves only on a read-strobe edge.

Cycle counts and other behaviour depend on the configuration and the request, so only the bench's cycle-accurate reference model can show them. This covers:
- the number of cycles in each phase;
- the address byte order in 8-bit mode;
- the narrowing of data;
- which incoming value is captured;
- that mid-transaction configuration changes have no effect.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  localparam int AD_W     = 16;
  localparam int ADDR_W   = 24;
  localparam int NARROW_W = 8;
  localparam int UP_W     = ADDR_W - AD_W;
  localparam int CNT_W    = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_AHI, PH_AHI_GAP, PH_ALO, PH_ALO_GAP, PH_STB, PH_HOLD, PH_DONE
  } phase_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [AD_W-1:0]   wdata;
    logic              write;
    logic              wide;
    logic [CNT_W-1:0]  ale_n;
    logic [CNT_W-1:0]  wait_n;
    logic [CNT_W-1:0]  hold_n;
  } xfer_t;
endpackage

// File: rtl/mxb_req_latch.sv
module mxb_req_latch
  import mxb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  xfer_t inc,
  output xfer_t cur
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cur <= '0;
    else if (accept) cur <= inc;
  end
endmodule

// File: rtl/mxb_cycle_timer.sv
module mxb_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mxb_phase_fsm.sv
module mxb_phase_fsm
  import mxb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             inc_wide,
  input  logic [CNT_W-1:0] inc_ale,
  input  logic [CNT_W-1:0] cur_ale,
  input  logic [CNT_W-1:0] cur_wait,
  input  logic [CNT_W-1:0] cur_hold,
  input  logic             expired,
  output phase_t           phase,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  phase_t nxt;

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    load_val = '0;
    unique case (phase)
      PH_IDLE: if (accept) begin
        nxt      = inc_wide ? PH_ALO : PH_AHI;
        load     = 1'b1;
        load_val = inc_ale;
      end
      PH_AHI: if (expired) begin
        nxt  = PH_AHI_GAP;
        load = 1'b1;
      end
      PH_AHI_GAP: begin
        nxt      = PH_ALO;
        load     = 1'b1;
        load_val = cur_ale;
      end
      PH_ALO: if (expired) begin
        nxt  = PH_ALO_GAP;
        load = 1'b1;
      end
      PH_ALO_GAP: begin
        nxt      = PH_STB;
        load     = 1'b1;
        load_val = cur_wait;
      end
      PH_STB: if (expired) begin
        load = 1'b1;
        if (cur_hold != '0) begin
          nxt      = PH_HOLD;
          load_val = cur_hold - 1'b1;
        end else begin
          nxt = PH_DONE;
        end
      end
      PH_HOLD: if (expired) nxt = PH_DONE;
      PH_DONE: nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  // R8
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |=> (phase == PH_IDLE));
endmodule

// File: rtl/mxb_pin_drive.sv
module mxb_pin_drive
  import mxb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [AD_W-1:0]   wdata,
  input  logic              write,
  input  logic              wide,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  logic [AD_W-1:0] upper_word;
  logic [AD_W-1:0] data_word;
  logic            data_phase;

  assign upper_word = {{(AD_W-UP_W){1'b0}}, addr[ADDR_W-1:AD_W]};
  assign data_word  = wide ? wdata : {{(AD_W-NARROW_W){1'b0}}, wdata[NARROW_W-1:0]};
  assign data_phase = (phase == PH_STB) || (phase == PH_HOLD);

  always_comb begin
    unique case (phase)
      PH_AHI, PH_AHI_GAP: ad_out = upper_word;
      PH_ALO, PH_ALO_GAP: ad_out = addr[AD_W-1:0];
      PH_STB, PH_HOLD:    ad_out = write ? data_word : '0;
      default:            ad_out = '0;
    endcase
  end

  assign ad_oe = (phase == PH_AHI) || (phase == PH_AHI_GAP) ||
                 (phase == PH_ALO) || (phase == PH_ALO_GAP) ||
                 (data_phase && write);
  assign ale   = (phase == PH_AHI) || (phase == PH_ALO);
  assign rd_n  = !((phase == PH_STB) && !write);
  assign wr_n  = !((phase == PH_STB) && write);

  // R4
  no_strobe_in_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n}) <= 1);
  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
endmodule

// File: rtl/mxbus_master.sv
module mxbus_master
  import mxb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [AD_W-1:0]       req_wdata,
  input  logic                  req_write,
  input  logic                  req_wide,
  input  logic [CNT_W-1:0]      cfg_ale,
  input  logic [CNT_W-1:0]      cfg_wait,
  input  logic [CNT_W-1:0]      cfg_hold,
  output logic                  rsp_done,
  output logic [AD_W-1:0]       rsp_rdata,
  output logic [AD_W-1:0]       bus_ad_out,
  output logic                  bus_ad_oe,
  input  logic [AD_W-1:0]       bus_ad_in,
  output logic                  bus_ale,
  output logic                  bus_rd_n,
  output logic                  bus_wr_n
);
  xfer_t            inc, cur;
  phase_t           phase;
  logic             accept, expired, load;
  logic [CNT_W-1:0] load_val;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_done  = (phase == PH_DONE);

  assign inc = '{addr: req_addr, wdata: req_wdata, write: req_write, wide: req_wide,
                 ale_n: cfg_ale, wait_n: cfg_wait, hold_n: cfg_hold};

  mxb_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .accept(accept), .inc(inc), .cur(cur)
  );

  mxb_cycle_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  mxb_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .inc_wide(req_wide), .inc_ale(cfg_ale),
    .cur_ale(cur.ale_n), .cur_wait(cur.wait_n), .cur_hold(cur.hold_n),
    .expired(expired), .phase(phase), .load(load), .load_val(load_val)
  );

  mxb_pin_drive u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .addr(cur.addr), .wdata(cur.wdata), .write(cur.write), .wide(cur.wide),
    .ad_out(bus_ad_out), .ad_oe(bus_ad_oe), .ale(bus_ale),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n)
  );

  // Read capture on the edge that ends the read strobe.
  always_ff @(posedge clk) begin
    if (!rst_n)
      rsp_rdata <= '0;
    else if ((phase == PH_STB) && expired && !cur.write)
      rsp_rdata <= cur.wide ? bus_ad_in
                            : {{(AD_W-NARROW_W){1'b0}}, bus_ad_in[NARROW_W-1:0]};
  end

  // R7
  rdata_on_rd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> $past(!bus_rd_n));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R1
  done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> req_ready);
endmodule

// File: tb/sim_mxbus_master.sv
module sim_mxbus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [3:0]  cfg_ale = '0, cfg_wait = '0, cfg_hold = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_in = 16'hACE1;
  logic        bus_ale, bus_rd_n, bus_wr_n;

  always #5 clk = ~clk;

  mxbus_master u0 (.*);

  typedef struct packed {
    logic ale; logic rd_n; logic wr_n; logic oe; logic [15:0] ad;
    logic done; logic cap; logic narrow; logic rchk; logic narrow_addr;
  } ent_t;

  ent_t        exp_q[$];
  logic [15:0] exp_rdata = '0;
  int          n_tot = 0, n_fail = 0, cyc = 0, wr_low = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic void add(input ent_t e, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(e);
  endfunction

  function automatic void model_txn(input logic [23:0] a, input logic [15:0] d,
                                    input logic wr, input logic wide,
                                    input int ca, input int cw, input int ch);
    ent_t e;
    logic [15:0] dv;
    dv = wide ? d : {8'h00, d[7:0]};
    e = '0; e.rd_n = 1; e.wr_n = 1; e.oe = 1; e.narrow = !wide; e.narrow_addr = !wide;
    if (!wide) begin
      e.ad = {8'h00, a[23:16]};
      e.ale = 1; add(e, ca + 1);
      e.ale = 0; add(e, 1);
    end
    e.ad = a[15:0];
    e.ale = 1; add(e, ca + 1);
    e.ale = 0; add(e, 1);
    e.narrow_addr = 0;
    if (wr) begin
      e.ad = dv; e.wr_n = 0; add(e, cw + 1);
      e.wr_n = 1; add(e, ch);
    end else begin
      e.oe = 0; e.ad = '0; e.rd_n = 0; e.cap = 0; add(e, cw);
      e.cap = 1; add(e, 1);
      e.cap = 0; e.rd_n = 1; add(e, ch);
    end
    e = '0; e.rd_n = 1; e.wr_n = 1; e.done = 1; e.rchk = !wr; e.narrow = !wide;
    add(e, 1);
  endfunction

  // Reference model advance: one entry per clock.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) exp_q.delete();
    else begin
      if (exp_q.size() != 0) begin
        if (exp_q[0].cap) exp_rdata = exp_q[0].narrow ? {8'h00, bus_ad_in[7:0]} : bus_ad_in;
        void'(exp_q.pop_front());
      end
      if (req_valid && req_ready)
        model_txn(req_addr, req_wdata, req_write, req_wide,
                  int'(cfg_ale), int'(cfg_wait), int'(cfg_hold));
    end
  end

  // Device side: a changing value on the incoming lines every cycle.
  always @(negedge clk)
    bus_ad_in <= {bus_ad_in[14:0], bus_ad_in[15] ^ bus_ad_in[13] ^ bus_ad_in[12] ^ bus_ad_in[10]};

  // Compare outputs with the model away from the active edge.
  always @(negedge clk) begin
    ent_t e;
    if (!rst_n) begin
      // R9
      chk(!bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && req_ready && !rsp_done,
          "R9 reset state", {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, req_ready, rsp_done}, 6'b011010);
    end else begin
      if (exp_q.size() != 0) e = exp_q[0];
      else begin e = '0; e.rd_n = 1; e.wr_n = 1; end
      if (!bus_wr_n) wr_low++;
      chk(req_ready == (exp_q.size() == 0), "R1 ready", int'(req_ready), int'(exp_q.size() == 0));
      chk(bus_ale == e.ale, "R2 ale", int'(bus_ale), int'(e.ale));
      chk(!(bus_ale && !(bus_rd_n && bus_wr_n)) && (bus_rd_n || bus_wr_n),
          "R4 strobes", {bus_ale, bus_rd_n, bus_wr_n}, 3'b011);
      chk(bus_wr_n == e.wr_n, "R5 wr_n", int'(bus_wr_n), int'(e.wr_n));
      chk(bus_rd_n == e.rd_n, "R6 rd_n", int'(bus_rd_n), int'(e.rd_n));
      chk(bus_ad_oe == e.oe, "R6 ad_oe", int'(bus_ad_oe), int'(e.oe));
      if (e.oe) begin
        if (e.narrow_addr) chk(bus_ad_out == e.ad, "R3 address", int'(bus_ad_out), int'(e.ad));
        else               chk(bus_ad_out == e.ad, "R5 bus value", int'(bus_ad_out), int'(e.ad));
      end
      chk(rsp_done == e.done, "R8 done", int'(rsp_done), int'(e.done));
      if (e.rchk) chk(rsp_rdata == exp_rdata, "R7 rdata", int'(rsp_rdata), int'(exp_rdata));
    end
  end

  task automatic issue(input logic [23:0] a, input logic [15:0] d, input logic wr,
                       input logic wide, input int ca, input int cw, input int ch);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_wdata = d; req_write = wr; req_wide = wide;
    cfg_ale = 4'(ca); cfg_wait = 4'(cw); cfg_hold = 4'(ch);
    @(posedge clk);
    while (!req_ready) @(posedge clk);
  endtask

  task automatic drop_and_wait();
    @(negedge clk);
    req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_tot++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R2 R5: 16-bit write
    issue(24'h00_1234, 16'hBEEF, 1, 1, 1, 2, 1); drop_and_wait();
    // R6 R7: 16-bit read
    issue(24'h00_5678, 16'h0000, 0, 1, 1, 3, 2); drop_and_wait();
    // R3 R5: 8-bit write, upper byte first
    issue(24'hA5_C3D2, 16'h77AA, 1, 0, 2, 1, 1); drop_and_wait();
    // R3 R7 R8: 8-bit read, minimum timing, no hold
    issue(24'h3C_0F0F, 16'h0000, 0, 0, 0, 0, 0); drop_and_wait();
    // R8: write with no hold
    issue(24'h00_FFFF, 16'h1357, 1, 1, 0, 0, 0); drop_and_wait();
    // maximum counts, 8-bit read
    issue(24'hFF_8001, 16'h0000, 0, 0, 15, 15, 15); drop_and_wait();
    // R1: back-to-back requests with valid held high
    issue(24'h12_3456, 16'hA1B2, 1, 0, 1, 1, 0);
    issue(24'h00_2468, 16'h0000, 0, 1, 0, 2, 1);
    issue(24'h7E_0001, 16'h0000, 0, 0, 1, 0, 1);
    drop_and_wait();
    // R10: configuration changed during the transaction
    wr_low = 0;
    issue(24'h00_4242, 16'hC0DE, 1, 1, 1, 2, 1);
    @(negedge clk);
    req_valid = 0; cfg_ale = 4'd9; cfg_wait = 4'd11; cfg_hold = 4'd7;
    while (exp_q.size() != 0) @(negedge clk);
    chk(wr_low == 3, "R10 strobe length", wr_low, 3);
    // mixed sweep
    for (int i = 0; i < 24; i++) begin
      issue(24'((i * 24'h2F1D3) ^ 24'h5A5A5A), 16'((i * 16'h3B7) ^ 16'hC3C3),
            i[0], i[1], i % 3, (i * 5) % 7, i % 4);
      if (i % 5 == 0) drop_and_wait();
    end
    drop_and_wait();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule